// File: doc/BRIEF.md
# Six-Pin GPIO Port with Serial Pin Takeover

This block is a small general-purpose I/O port that sits on a byte-wide register bus. It holds two registers. One is a per-pin direction register, and the other is an output data latch. Each pin has its own output value, output enable and input level. The pin inputs are synchronized with two flops before anything inside the block uses them.

Reading the data register returns a value built pin by pin. A pin set as an output returns its latch bit, and a pin set as an input returns its synchronized level. The latch can be written at any time, whatever the direction bit. Software can therefore load the latch before it turns a pin into an output.

A serial-enable input hands the two lowest pins to an external serial engine. Pin 0 then drives the transmit signal out, and pin 1 becomes the receive input. The direction register keeps its stored value while this takeover is active.

Top module: `gpio_port_serial`

## Requirements
- R1: After reset, the direction register and the data latch are both 0. So all `pin_oe` bits and all `pin_out` bits are 0.
- R2: A write with `bus_wr`=1 to address 0xC stores `bus_wdata[5:0]` as the direction bits. The new value is visible at the clock edge that samples the strobe. While `ser_en`=0, `pin_oe[i]` equals direction bit i, and 1 means output.
- R3: A write to address 0x8 stores `bus_wdata[5:0]` in the data latch, whatever the direction bits are. While `ser_en`=0, `pin_out[i]` equals latch bit i.
- R4: A read of address 0x8 returns the following value in bits 5:0. Bit i is the latch bit when direction bit i is 1. It is the level of `pin_in[i]` from two rising clock edges earlier when direction bit i is 0.
- R5: Bits 7:6 of any read are 0. A read of address 0xC returns the stored direction bits in bits 5:0.
- R6: A read of any address other than 0x8 or 0xC returns 0. A write to such an address changes neither register.
- R7: `bus_rdata` is 0 whenever `bus_rd`=0, and the read path is combinational from `bus_addr`.
- R8: While `ser_en`=1, `pin_oe[0]`=1, `pin_out[0]`=`ser_tx` and `pin_oe[1]`=0. Pins 5:2 keep following their direction and latch bits.
- R9: While `ser_en`=1, `ser_rx` equals the level of `pin_in[1]` from two rising edges earlier. While `ser_en`=0, `ser_rx` is held at 1, the idle level.
- R10: Setting `ser_en` leaves the stored direction bits unchanged, as read back from 0xC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| pin_in | input | 6 | Pin input levels |
| pin_out | output | 6 | Pin output values |
| pin_oe | output | 6 | Pin output enables, 1 means driving |
| ser_en | input | 1 | Serial takeover of pins 0 and 1 |
| ser_tx | input | 1 | Serial transmit data |
| ser_rx | output | 1 | Serial receive data |

## Verification
The bench builds the block with its default six pins and 4-bit addresses. At that size, every one of the 64 direction patterns can be combined with every one of the 64 latch patterns, with a third pattern on the pin inputs. This checks the per-pin read selection over its whole space. The small address space also lets the bench write to and read from all 16 addresses, which proves that undefined offsets stay inert. With the serial takeover active, the bench sweeps all direction patterns against both transmit levels and both receive levels.

// File: rtl/gpio_port_serial.sv
module gpio_port_serial #(
  parameter int NPINS = 6,
  parameter int AW = 4,
  parameter logic [AW-1:0] DATA_ADDR = 4'h8,
  parameter logic [AW-1:0] DIR_ADDR = 4'hC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  input  logic             ser_en,
  input  logic             ser_tx,
  output logic             ser_rx
);
  localparam int DW = 8;

  logic [NPINS-1:0] dir_q, out_q, meta_q, lvl_q, rd_pins;
  logic sel_data, sel_dir;

  assign sel_data = bus_addr == DATA_ADDR;
  assign sel_dir  = bus_addr == DIR_ADDR;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      out_q <= '0;
    end else if (bus_wr) begin
      if (sel_dir)  dir_q <= bus_wdata[NPINS-1:0];
      if (sel_data) out_q <= bus_wdata[NPINS-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      lvl_q  <= '0;
    end else begin
      meta_q <= pin_in;
      lvl_q  <= meta_q;
    end
  end

  assign rd_pins = (dir_q & out_q) | (~dir_q & lvl_q);

  always_comb begin
    bus_rdata = '0;
    if (bus_rd && sel_data) bus_rdata = DW'(rd_pins);
    else if (bus_rd && sel_dir) bus_rdata = DW'(dir_q);
  end

  always_comb begin
    pin_out = out_q;
    pin_oe  = dir_q;
    if (ser_en) begin
      pin_out[0] = ser_tx;
      pin_oe[0]  = 1'b1;
      pin_oe[1]  = 1'b0;
    end
  end

  assign ser_rx = ser_en ? lvl_q[1] : 1'b1;
endmodule

// File: rtl/gpio_port_serial_chk.sv
module gpio_port_serial_chk #(
  parameter int NPINS = 6,
  parameter int AW = 4,
  parameter logic [AW-1:0] DATA_ADDR = 4'h8,
  parameter logic [AW-1:0] DIR_ADDR = 4'hC
) (
  input logic             clk,
  input logic             rst_n,
  input logic [AW-1:0]    bus_addr,
  input logic             bus_wr,
  input logic             bus_rd,
  input logic [7:0]       bus_wdata,
  input logic [7:0]       bus_rdata,
  input logic [NPINS-1:0] pin_in,
  input logic [NPINS-1:0] pin_out,
  input logic [NPINS-1:0] pin_oe,
  input logic             ser_en,
  input logic             ser_tx,
  input logic             ser_rx,
  input logic [NPINS-1:0] dir_q,
  input logic [NPINS-1:0] out_q
);
  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) since_rst <= '0;
    else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;

  AST_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == DIR_ADDR) |=> (ser_en || pin_oe == $past(bus_wdata[NPINS-1:0]))); // R2
  AST_LATCH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == DATA_ADDR) |=> (ser_en || pin_out == $past(bus_wdata[NPINS-1:0]))); // R3
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == DATA_ADDR) |=> $stable(out_q)); // R6
  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == DIR_ADDR) |=> $stable(dir_q)); // R10
  AST_HIGH_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[7:6] == 2'b00); // R5
  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && (bus_addr == DATA_ADDR || bus_addr == DIR_ADDR)) |-> bus_rdata == 8'h00); // R7
  AST_SER_OVERRIDE: assert property (@(posedge clk) disable iff (!rst_n)
    ser_en |-> (pin_oe[1:0] == 2'b01 && pin_out[0] == ser_tx)); // R8
  AST_RX_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_en && since_rst == 2'd2) |-> ser_rx == $past(pin_in[1], 2)); // R9
  AST_RX_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_en |-> ser_rx); // R9
endmodule

bind gpio_port_serial gpio_port_serial_chk #(
  .NPINS(NPINS), .AW(AW), .DATA_ADDR(DATA_ADDR), .DIR_ADDR(DIR_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out),
  .pin_oe(pin_oe), .ser_en(ser_en), .ser_tx(ser_tx), .ser_rx(ser_rx),
  .dir_q(dir_q), .out_q(out_q)
);

// File: tb/gpio_port_serial_test.sv
module gpio_port_serial_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] A_DATA = 4'h8;
  localparam logic [3:0] A_DIR  = 4'hC;

  logic clk = 0, rst_n = 0;
  logic [3:0] bus_addr = '0;
  logic bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic [5:0] pin_in = '0, pin_out, pin_oe;
  logic ser_en = 0, ser_tx = 0, ser_rx;
  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_port_serial uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .ser_en(ser_en), .ser_tx(ser_tx), .ser_rx(ser_rx)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1;
    #1 d = bus_rdata;
    bus_rd = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    check("R1 oe", {2'b0, pin_oe}, 8'h00);
    check("R1 out", {2'b0, pin_out}, 8'h00);
    rst_n = 1;
    @(negedge clk);
    rd(A_DIR, v);  check("R1 dir", v, 8'h00);
    check("R9 idle rx", {7'b0, ser_rx}, 8'h01);

    // R2 R3 R4 exhaustive sweep of direction x latch
    for (int d = 0; d < 64; d++) begin
      for (int l = 0; l < 64; l++) begin
        logic [5:0] p;
        p = 6'(~l ^ (d << 1) ^ (l >> 2));
        @(negedge clk);
        pin_in = p;
        wr(A_DATA, 8'(l) | 8'hC0);
        wr(A_DIR, 8'(d));
        check("R2 oe", {2'b0, pin_oe}, 8'(d));
        check("R3 out", {2'b0, pin_out}, 8'(l));
        rd(A_DATA, v);
        check("R4 read", v, 8'((l & d) | (p & ~d)));
      end
    end

    // R4 synchronizer latency with all pins as inputs
    wr(A_DIR, 8'h00);
    pin_in = 6'h00;
    repeat (3) @(negedge clk);
    pin_in = 6'h2A;
    @(negedge clk); rd(A_DATA, v); check("R4 one edge", v, 8'h00);
    @(negedge clk); rd(A_DATA, v); check("R4 two edges", v, 8'h2A);

    // R5 high bits
    wr(A_DIR, 8'hFF);
    rd(A_DIR, v); check("R5 dir readback", v, 8'h3F);
    wr(A_DATA, 8'hFF);
    rd(A_DATA, v); check("R5 data high", v, 8'h3F);

    // R6 undefined addresses
    wr(A_DATA, 8'h15); wr(A_DIR, 8'h2B);
    for (int a = 0; a < 16; a++) begin
      if (4'(a) == A_DATA || 4'(a) == A_DIR) continue;
      wr(4'(a), 8'hFF);
      rd(4'(a), v); check("R6 undefined read", v, 8'h00);
      wr(4'(a), 8'h00);
    end
    rd(A_DIR, v); check("R6 dir kept", v, 8'h2B);
    check("R6 latch kept", {2'b0, pin_out}, 8'h15);

    // R7 no read strobe
    for (int a = 0; a < 16; a++) begin
      bus_addr = 4'(a); #1 check("R7 rd low", bus_rdata, 8'h00);
    end

    // R8 R9 R10 serial takeover sweep
    wr(A_DATA, 8'h3C);
    for (int d = 0; d < 64; d++) begin
      wr(A_DIR, 8'(d));
      for (int t = 0; t < 4; t++) begin
        @(negedge clk);
        ser_en = 1; ser_tx = t[0]; pin_in = {4'h0, t[1], 1'b0};
        @(negedge clk); @(negedge clk);
        check("R8 oe", {2'b0, pin_oe}, 8'((d & 6'h3C) | 1));
        check("R8 out", {2'b0, pin_out}, 8'(6'h3C | t[0]));
        check("R9 rx", {7'b0, ser_rx}, 8'(t[1]));
        rd(A_DIR, v); check("R10 dir kept", v, 8'(d));
      end
      ser_en = 0;
      #1 check("R9 rx idle", {7'b0, ser_rx}, 8'h01);
      check("R2 oe restored", {2'b0, pin_oe}, 8'(d));
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule